// File: doc/BRIEF.md
# Moore State-Table Equivalence Engine

This block takes the transition table of a fully specified Moore machine with one input bit and finds which of its states can never be told apart from the outside. Software or a sequencer first loads the table through a write port. Each write gives one state's output bit and its successor for input 0 and for input 1. The number of live states is set through a separate configuration port. A start pulse then launches the engine.

The engine refines a labelling of the states pass by pass. Before the first pass every state carries label 0. In each pass, the engine walks the live states from index 0 upward. For each state it forms a key from four things: the state's output, its current label, and the current labels of its two successors. It hands out fresh labels in the order in which new keys first appear. When a pass produces no more classes than the pass before it, the partition has settled. The engine then raises `done` for one cycle and reports the class count and the number of passes. The label of any state can be read through a combinational lookup port.

The controller runs through four named states:
- `ST_IDLE`: waits for `start`. If the table is invalid it moves to `ST_FINISH`; otherwise it moves to `ST_SCAN`.
- `ST_SCAN`: handles one state per cycle. It moves to `ST_COMMIT` after the last live state.
- `ST_COMMIT`: adopts the new labels. It moves to `ST_FINISH` if the class count did not grow, and otherwise back to `ST_SCAN`.
- `ST_FINISH`: pulses `done` and returns to `ST_IDLE`.

Top module: `fsm_minimizer`

## Requirements
- R1: After reset, `busy`, `done` and `error` are 0, and `num_classes` and `rounds` read 0.
- R2: After a run without error, two live states share a label exactly when no input sequence gives different output sequences from them.
- R3: Labels are canonical. State 0 has label 0, and each later state carries either the label of some lower-indexed state or the next unused label, one above the largest label used below it.
- R4: After a run without error, `num_classes` equals the number of distinct labels among the live states, and every live label is below `num_classes`.
- R5: `rounds` counts the labelling passes, including the final pass that leaves the class count unchanged. A table whose states all share one output takes 1 pass, and a table whose longest shortest distinguishing sequence has length k takes k+1 passes.
- R6: `busy` is 1 from the cycle after an accepted `start` until the cycle before `done`. `done` is a single-cycle pulse and is never high together with `busy`.
- R7: A `start` pulse that arrives while `busy` is 1 is ignored: it neither restarts nor extends the run.
- R8: At `start`, the table is invalid if `cfg_n_states` is 0, if it exceeds the capacity, or if any live state has a successor index at or above the live count. An invalid table gives `done` with `error`=1, `num_classes`=0 and `rounds`=0, and no pass is run. Table entries at indices at or above the live count are not checked. A valid run clears `error`.
- R9: Table writes and configuration writes that arrive while `busy` is 1 are dropped.
- R10: For the 8-state table 0:(3,2,0) 1:(5,7,0) 2:(4,3,1) 3:(0,4,0) 4:(2,0,1) 5:(5,1,1) 6:(1,7,0) 7:(2,6,1), where each entry is (successor for input 0, successor for input 1, output), the labels are 0,1,2,0,2,3,4,5, with 6 classes and 5 passes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| cfg_en | input | 1 | Load `cfg_n_states` into the live-count register |
| cfg_n_states | input | CW | Number of live states |
| wr_en | input | 1 | Write one table row |
| wr_state | input | IW | Row index to write |
| wr_z | input | 1 | Moore output of that state |
| wr_ns0 | input | IW | Successor for input 0 |
| wr_ns1 | input | IW | Successor for input 1 |
| start | input | 1 | Launch a minimization run |
| rd_state | input | IW | State whose label is read |
| busy | output | 1 | Run in progress |
| done | output | 1 | One-cycle completion pulse |
| error | output | 1 | Last run rejected the table |
| num_classes | output | CW | Number of equivalence classes |
| rounds | output | CW | Number of labelling passes |
| rd_label | output | IW | Class label of `rd_state` |

## Verification
The bench builds the engine with its default capacity of 16 states, which gives 4-bit labels and 5-bit counts. With this capacity, the bench covers live counts from a single state up to a full table. That range includes tables where every state is its own class, which drives the label allocator to its last free slot. The bench also covers tables that need many passes, and tables whose out-of-range rows lie above the live count. The reference values are computed by a pairwise distinguishing-length search, so the pass count is checked against the longest distinguishing sequence, not against a second copy of the refinement.

// File: rtl/fsmmin_pkg.sv
package fsmmin_pkg;

    typedef enum logic [1:0] {
        ST_IDLE   = 2'd0,
        ST_SCAN   = 2'd1,
        ST_COMMIT = 2'd2,
        ST_FINISH = 2'd3
    } ctrl_st_e;

endpackage

// File: rtl/fsmmin_table.sv
module fsmmin_table #(
    parameter int N_MAX = 16,
    parameter int IW    = 4,
    parameter int CW    = 5
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_state,
    input  logic          wr_z,
    input  logic [IW-1:0] wr_ns0,
    input  logic [IW-1:0] wr_ns1,
    input  logic          cfg_en,
    input  logic [CW-1:0] cfg_n_states,
    input  logic [IW-1:0] rd_idx,
    output logic          rd_z,
    output logic [IW-1:0] rd_ns0,
    output logic [IW-1:0] rd_ns1,
    output logic [CW-1:0] n_live,
    output logic          range_bad
);

    logic          z_q   [N_MAX];
    logic [IW-1:0] ns0_q [N_MAX];
    logic [IW-1:0] ns1_q [N_MAX];
    logic [CW-1:0] n_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            n_q <= '0;
            for (int i = 0; i < N_MAX; i++) begin
                z_q[i]   <= 1'b0;
                ns0_q[i] <= '0;
                ns1_q[i] <= '0;
            end
        end else begin
            if (cfg_en) begin
                n_q <= cfg_n_states;
            end
            if (wr_en) begin
                z_q[wr_state]   <= wr_z;
                ns0_q[wr_state] <= wr_ns0;
                ns1_q[wr_state] <= wr_ns1;
            end
        end
    end

    assign rd_z   = z_q[rd_idx];
    assign rd_ns0 = ns0_q[rd_idx];
    assign rd_ns1 = ns1_q[rd_idx];
    assign n_live = n_q;

    // A live row is out of range if either successor is not below the live count
    always_comb begin
        range_bad = (n_q == '0) || (n_q > CW'(N_MAX));
        for (int i = 0; i < N_MAX; i++) begin
            if (CW'(i) < n_q) begin
                if ({1'b0, ns0_q[i]} >= n_q || {1'b0, ns1_q[i]} >= n_q) begin
                    range_bad = 1'b1;
                end
            end
        end
    end

endmodule

// File: rtl/fsmmin_classify.sv
module fsmmin_classify #(
    parameter int N_MAX = 16,
    parameter int IW    = 4,
    parameter int CW    = 5,
    parameter int SW    = 1 + 3 * IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clr,
    input  logic          step,
    input  logic [SW-1:0] sig,
    output logic [IW-1:0] cls_id,
    output logic [CW-1:0] cls_cnt
);

    logic [SW-1:0] key_q [N_MAX];
    logic [CW-1:0] cnt_q;
    logic [N_MAX-1:0] hit;
    logic          found;
    logic [IW-1:0] hit_id;

    // One comparator per allocated slot
    for (genvar j = 0; j < N_MAX; j++) begin : g_cmp
        assign hit[j] = (CW'(j) < cnt_q) && (key_q[j] == sig);
    end

    // Lowest matching slot wins; keys are distinct so at most one matches
    always_comb begin
        found  = 1'b0;
        hit_id = '0;
        for (int j = N_MAX - 1; j >= 0; j--) begin
            if (hit[j]) begin
                found  = 1'b1;
                hit_id = IW'(j);
            end
        end
    end

    assign cls_id  = found ? hit_id : cnt_q[IW-1:0];
    assign cls_cnt = cnt_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            for (int j = 0; j < N_MAX; j++) begin
                key_q[j] <= '0;
            end
        end else if (clr) begin
            cnt_q <= '0;
        end else if (step && !found) begin
            key_q[cnt_q[IW-1:0]] <= sig;
            cnt_q                <= cnt_q + CW'(1);
        end
    end

endmodule

// File: rtl/fsmmin_ctrl.sv
module fsmmin_ctrl
    import fsmmin_pkg::*;
#(
    parameter int N_MAX = 16,
    parameter int IW    = 4,
    parameter int CW    = 5,
    parameter int SW    = 1 + 3 * IW
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          range_bad,
    input  logic [CW-1:0] n_live,
    input  logic          tbl_z,
    input  logic [IW-1:0] tbl_ns0,
    input  logic [IW-1:0] tbl_ns1,
    output logic [IW-1:0] tbl_idx,
    input  logic [IW-1:0] cls_id,
    input  logic [CW-1:0] cls_cnt,
    output logic          cls_clr,
    output logic          cls_step,
    output logic [SW-1:0] sig,
    input  logic [IW-1:0] rd_state,
    output logic [IW-1:0] rd_label,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [CW-1:0] num_classes,
    output logic [CW-1:0] rounds
);

    ctrl_st_e      state_q, state_d;
    logic [IW-1:0] idx_q;
    logic [IW-1:0] cur_lbl_q [N_MAX];
    logic [IW-1:0] nxt_lbl_q [N_MAX];
    logic [CW-1:0] prev_cnt_q;
    logic [CW-1:0] rounds_q;
    logic [CW-1:0] classes_q;
    logic          err_q;
    logic          accept;
    logic          last_row;
    logic          settled;

    assign accept   = (state_q == ST_IDLE) && start;
    assign last_row = ({1'b0, idx_q} == (n_live - CW'(1)));
    assign settled  = (cls_cnt == prev_cnt_q);

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
        end else begin
            state_q <= state_d;
        end
    end

    // Transitions
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE: begin
                if (start) begin
                    state_d = range_bad ? ST_FINISH : ST_SCAN;
                end
            end
            ST_SCAN: begin
                if (last_row) begin
                    state_d = ST_COMMIT;
                end
            end
            ST_COMMIT: begin
                state_d = settled ? ST_FINISH : ST_SCAN;
            end
            ST_FINISH: begin
                state_d = ST_IDLE;
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            idx_q      <= '0;
            prev_cnt_q <= '0;
            rounds_q   <= '0;
            classes_q  <= '0;
            err_q      <= 1'b0;
            for (int i = 0; i < N_MAX; i++) begin
                cur_lbl_q[i] <= '0;
                nxt_lbl_q[i] <= '0;
            end
        end else begin
            unique case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        idx_q      <= '0;
                        prev_cnt_q <= CW'(1);
                        rounds_q   <= '0;
                        classes_q  <= '0;
                        err_q      <= range_bad;
                        for (int i = 0; i < N_MAX; i++) begin
                            cur_lbl_q[i] <= '0;
                            nxt_lbl_q[i] <= '0;
                        end
                    end
                end
                ST_SCAN: begin
                    nxt_lbl_q[idx_q] <= cls_id;
                    idx_q            <= idx_q + IW'(1);
                end
                ST_COMMIT: begin
                    rounds_q   <= rounds_q + CW'(1);
                    prev_cnt_q <= cls_cnt;
                    idx_q      <= '0;
                    for (int i = 0; i < N_MAX; i++) begin
                        cur_lbl_q[i] <= nxt_lbl_q[i];
                    end
                    if (settled) begin
                        classes_q <= cls_cnt;
                    end
                end
                ST_FINISH: begin
                end
                default: begin
                end
            endcase
        end
    end

    // Key: output, own label, labels of both successors
    assign tbl_idx  = idx_q;
    assign sig      = {tbl_z, cur_lbl_q[idx_q], cur_lbl_q[tbl_ns0], cur_lbl_q[tbl_ns1]};
    assign cls_clr  = accept || (state_q == ST_COMMIT);
    assign cls_step = (state_q == ST_SCAN);
    assign rd_label = cur_lbl_q[rd_state];

    // Outputs
    always_comb begin
        busy        = (state_q == ST_SCAN) || (state_q == ST_COMMIT);
        done        = (state_q == ST_FINISH);
        error       = err_q;
        num_classes = classes_q;
        rounds      = rounds_q;
    end

endmodule

// File: rtl/fsm_minimizer.sv
module fsm_minimizer #(
    parameter int N_MAX = 16,
    parameter int IW    = (N_MAX > 1) ? $clog2(N_MAX) : 1,
    parameter int CW    = IW + 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          cfg_en,
    input  logic [CW-1:0] cfg_n_states,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_state,
    input  logic          wr_z,
    input  logic [IW-1:0] wr_ns0,
    input  logic [IW-1:0] wr_ns1,
    input  logic          start,
    input  logic [IW-1:0] rd_state,
    output logic          busy,
    output logic          done,
    output logic          error,
    output logic [CW-1:0] num_classes,
    output logic [CW-1:0] rounds,
    output logic [IW-1:0] rd_label
);

    localparam int SW = 1 + 3 * IW;

    logic          tbl_we, cfg_we;
    logic [IW-1:0] tbl_idx;
    logic          tbl_z;
    logic [IW-1:0] tbl_ns0, tbl_ns1;
    logic [CW-1:0] n_live;
    logic          range_bad;
    logic [IW-1:0] cls_id;
    logic [CW-1:0] cls_cnt;
    logic          cls_clr, cls_step;
    logic [SW-1:0] sig;

    assign tbl_we = wr_en && !busy;
    assign cfg_we = cfg_en && !busy;

    fsmmin_table #(.N_MAX(N_MAX), .IW(IW), .CW(CW)) u_table (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_en        (tbl_we),
        .wr_state     (wr_state),
        .wr_z         (wr_z),
        .wr_ns0       (wr_ns0),
        .wr_ns1       (wr_ns1),
        .cfg_en       (cfg_we),
        .cfg_n_states (cfg_n_states),
        .rd_idx       (tbl_idx),
        .rd_z         (tbl_z),
        .rd_ns0       (tbl_ns0),
        .rd_ns1       (tbl_ns1),
        .n_live       (n_live),
        .range_bad    (range_bad)
    );

    fsmmin_classify #(.N_MAX(N_MAX), .IW(IW), .CW(CW), .SW(SW)) u_classify (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr     (cls_clr),
        .step    (cls_step),
        .sig     (sig),
        .cls_id  (cls_id),
        .cls_cnt (cls_cnt)
    );

    fsmmin_ctrl #(.N_MAX(N_MAX), .IW(IW), .CW(CW), .SW(SW)) u_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .start       (start),
        .range_bad   (range_bad),
        .n_live      (n_live),
        .tbl_z       (tbl_z),
        .tbl_ns0     (tbl_ns0),
        .tbl_ns1     (tbl_ns1),
        .tbl_idx     (tbl_idx),
        .cls_id      (cls_id),
        .cls_cnt     (cls_cnt),
        .cls_clr     (cls_clr),
        .cls_step    (cls_step),
        .sig         (sig),
        .rd_state    (rd_state),
        .rd_label    (rd_label),
        .busy        (busy),
        .done        (done),
        .error       (error),
        .num_classes (num_classes),
        .rounds      (rounds)
    );

endmodule

// File: rtl/fsmmin_checker.sv
module fsmmin_checker #(
    parameter int N_MAX = 16,
    parameter int IW    = 4,
    parameter int CW    = 5
) (
    input logic          clk,
    input logic          rst_n,
    input logic [IW-1:0] rd_state,
    input logic          busy,
    input logic          done,
    input logic          error,
    input logic [CW-1:0] num_classes,
    input logic [CW-1:0] rounds,
    input logic [IW-1:0] rd_label
);

    assert_done_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_busy_done_excl_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !(busy && done));

    assert_busy_until_done_R7: assert property (@(posedge clk) disable iff (!rst_n)
        busy |=> (busy || done));

    assert_error_no_classes_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (done && error) |-> (num_classes == '0 && rounds == '0));

    assert_class_count_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> (num_classes >= CW'(1) && num_classes <= CW'(N_MAX)));

    assert_rounds_bound_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !error) |-> (rounds >= CW'(1) && rounds <= num_classes));

    assert_first_label_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && num_classes != '0 && rd_state == '0) |-> (rd_label == '0));

    assert_label_below_count_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && num_classes != '0) |-> ({1'b0, rd_label} < num_classes));

endmodule

bind fsm_minimizer fsmmin_checker #(.N_MAX(N_MAX), .IW(IW), .CW(CW)) u_fsmmin_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .rd_state    (rd_state),
    .busy        (busy),
    .done        (done),
    .error       (error),
    .num_classes (num_classes),
    .rounds      (rounds),
    .rd_label    (rd_label)
);

// File: tb/sim_fsm_minimizer.sv
`timescale 1ns/1ps
module sim_fsm_minimizer;

    localparam int N  = 16;
    localparam int IW = 4;
    localparam int CW = 5;
    localparam int INF = 1000;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_en = 1'b0;
    logic [CW-1:0] cfg_n_states = '0;
    logic          wr_en = 1'b0;
    logic [IW-1:0] wr_state = '0;
    logic          wr_z = 1'b0;
    logic [IW-1:0] wr_ns0 = '0;
    logic [IW-1:0] wr_ns1 = '0;
    logic          start = 1'b0;
    logic [IW-1:0] rd_state = '0;
    logic          busy, done, error;
    logic [CW-1:0] num_classes, rounds;
    logic [IW-1:0] rd_label;

    int checks = 0;
    int errors = 0;
    int ref_z  [N];
    int ref_n0 [N];
    int ref_n1 [N];
    int exp_lbl[N];
    int exp_cls, exp_rounds;
    int seed = 32'h1357_2468;

    always #2.5 clk = ~clk;

    fsm_minimizer #(.N_MAX(N)) u0 (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_n_states(cfg_n_states),
        .wr_en(wr_en), .wr_state(wr_state), .wr_z(wr_z), .wr_ns0(wr_ns0), .wr_ns1(wr_ns1),
        .start(start), .rd_state(rd_state), .busy(busy), .done(done), .error(error),
        .num_classes(num_classes), .rounds(rounds), .rd_label(rd_label)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    function automatic int rnd(input int m);
        seed = seed * 1103515245 + 12345;
        return ((seed >>> 8) & 32'h7fffff) % m;
    endfunction

    // Reference: pairwise shortest distinguishing length, then first-appearance labels
    task automatic compute_ref(input int n);
        int d[N][N];
        int chg, mx, cnt, a, b;
        for (int i = 0; i < n; i++)
            for (int j = 0; j < n; j++)
                d[i][j] = (ref_z[i] != ref_z[j]) ? 1 : INF;
        chg = 1;
        while (chg != 0) begin
            chg = 0;
            for (int i = 0; i < n; i++)
                for (int j = 0; j < n; j++) begin
                    a = d[ref_n0[i]][ref_n0[j]];
                    b = d[ref_n1[i]][ref_n1[j]];
                    if (b < a) a = b;
                    if (a < INF && a + 1 < d[i][j]) begin
                        d[i][j] = a + 1;
                        chg = 1;
                    end
                end
        end
        mx = 0;
        for (int i = 0; i < n; i++)
            for (int j = 0; j < n; j++)
                if (d[i][j] < INF && d[i][j] > mx) mx = d[i][j];
        exp_rounds = mx + 1;
        cnt = 0;
        for (int i = 0; i < n; i++) begin
            exp_lbl[i] = -1;
            for (int j = 0; j < i; j++)
                if (exp_lbl[i] < 0 && d[i][j] == INF) exp_lbl[i] = exp_lbl[j];
            if (exp_lbl[i] < 0) begin
                exp_lbl[i] = cnt;
                cnt++;
            end
        end
        exp_cls = cnt;
    endtask

    task automatic load(input int n, input int rows);
        @(negedge clk);
        cfg_en = 1'b1;
        cfg_n_states = CW'(n);
        @(negedge clk);
        cfg_en = 1'b0;
        for (int i = 0; i < rows; i++) begin
            wr_en = 1'b1;
            wr_state = IW'(i);
            wr_z = ref_z[i][0];
            wr_ns0 = IW'(ref_n0[i]);
            wr_ns1 = IW'(ref_n1[i]);
            @(negedge clk);
        end
        wr_en = 1'b0;
    endtask

    // Pulses start and waits for done; checks busy and the done pulse (R6)
    task automatic run(input bit expect_err);
        int cyc;
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (!expect_err) chk("R6 busy after start", int'(busy), 1);
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R6 done reached", int'(done), 1);
        @(negedge clk);
        chk("R6 done single cycle", int'(done), 0);
        chk("R7 no restart after done", int'(busy), 0);
    endtask

    task automatic check_labels(input string tag, input int n);
        chk({tag, " R8 error clear"}, int'(error), 0);
        chk({tag, " R4 class count"}, int'(num_classes), exp_cls);
        chk({tag, " R5 rounds"}, int'(rounds), exp_rounds);
        for (int i = 0; i < n; i++) begin
            rd_state = IW'(i);
            #1;
            chk({tag, " R2 R3 label"}, int'(rd_label), exp_lbl[i]);
        end
    endtask

    task automatic t_reset;
        chk("R1 busy", int'(busy), 0);
        chk("R1 done", int'(done), 0);
        chk("R1 error", int'(error), 0);
        chk("R1 classes", int'(num_classes), 0);
        chk("R1 rounds", int'(rounds), 0);
    endtask

    task automatic set_example;
        int t0[8] = '{3, 5, 4, 0, 2, 5, 1, 2};
        int t1[8] = '{2, 7, 3, 4, 0, 1, 7, 6};
        int tz[8] = '{0, 0, 1, 0, 1, 1, 0, 1};
        for (int i = 0; i < 8; i++) begin
            ref_n0[i] = t0[i];
            ref_n1[i] = t1[i];
            ref_z[i] = tz[i];
        end
    endtask

    task automatic t_example;
        int want[8] = '{0, 1, 2, 0, 2, 3, 4, 5};
        set_example();
        load(8, 8);
        run(1'b0);
        chk("R10 classes", int'(num_classes), 6);
        chk("R10 rounds", int'(rounds), 5);
        for (int i = 0; i < 8; i++) begin
            rd_state = IW'(i);
            #1;
            chk("R10 label", int'(rd_label), want[i]);
        end
        compute_ref(8);
        check_labels("example", 8);
    endtask

    task automatic t_uniform;
        for (int i = 0; i < 5; i++) begin
            ref_z[i] = 1;
            ref_n0[i] = rnd(5);
            ref_n1[i] = rnd(5);
        end
        load(5, 5);
        run(1'b0);
        chk("R5 single pass", int'(rounds), 1);
        chk("R4 single class", int'(num_classes), 1);
    endtask

    task automatic t_random;
        for (int t = 0; t < 14; t++) begin
            int n;
            if (t == 0) n = 16;
            else if (t == 1) n = 1;
            else n = 2 + rnd(15);
            for (int i = 0; i < n; i++) begin
                ref_z[i] = rnd(2);
                ref_n0[i] = rnd(n);
                ref_n1[i] = rnd(n);
            end
            if (t == 2) begin
                // Shift ring: all states distinct, many passes
                for (int i = 0; i < n; i++) begin
                    ref_z[i] = (i == 0) ? 1 : 0;
                    ref_n0[i] = (i + 1) % n;
                    ref_n1[i] = (i + 1) % n;
                end
            end
            load(n, n);
            run(1'b0);
            compute_ref(n);
            check_labels("random", n);
        end
    endtask

    task automatic t_errors;
        for (int i = 0; i < 4; i++) begin
            ref_z[i] = i % 2;
            ref_n0[i] = (i + 1) % 4;
            ref_n1[i] = i;
        end
        ref_n1[2] = 7;
        load(4, 4);
        run(1'b1);
        chk("R8 bad successor error", int'(error), 1);
        chk("R8 bad successor classes", int'(num_classes), 0);
        chk("R8 bad successor rounds", int'(rounds), 0);
        // Rows above the live count are not checked
        ref_n1[2] = 1;
        for (int i = 4; i < 8; i++) begin
            ref_z[i] = 0;
            ref_n0[i] = 15;
            ref_n1[i] = 14;
        end
        load(4, 8);
        run(1'b0);
        compute_ref(4);
        check_labels("R8 dead rows", 4);
        load(0, 0);
        run(1'b1);
        chk("R8 zero count error", int'(error), 1);
        load(17, 0);
        run(1'b1);
        chk("R8 oversize count error", int'(error), 1);
    endtask

    task automatic t_busy_ignore;
        int cyc;
        set_example();
        load(8, 8);
        compute_ref(8);
        @(negedge clk);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        @(negedge clk);
        @(negedge clk);
        // Stimulus during the run
        start = 1'b1;
        wr_en = 1'b1;
        wr_state = 4'd0;
        wr_z = 1'b1;
        wr_ns0 = 4'd1;
        wr_ns1 = 4'd1;
        cfg_en = 1'b1;
        cfg_n_states = 5'd3;
        @(negedge clk);
        start = 1'b0;
        wr_en = 1'b0;
        cfg_en = 1'b0;
        cyc = 0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            cyc++;
        end
        chk("R7 run completes", int'(done), 1);
        @(negedge clk);
        chk("R7 start while busy ignored", int'(busy), 0);
        check_labels("R7 result", 8);
        // Rerun without reloading: the table and count must be unchanged
        run(1'b0);
        check_labels("R9 table kept", 8);
    endtask

    initial begin
        #(5.0 * 150000);
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_example();
        t_uniform();
        t_random();
        t_errors();
        t_busy_ignore();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule